// File: doc/BRIEF.md
# Vectored External Interrupt Controller

This block gathers the interrupt request lines of many peripheral devices and merges them into a single external interrupt request toward the processor. Each request line has a fixed index that is set by its wiring. Software gives each line a 4-bit priority, and the block arbitrates among the pending lines. When the processor takes the interrupt, the block records which source is now in service and raises the priority threshold, so only more urgent sources can interrupt again.

Two delivery modes are offered. In software vector mode, the processor reads an acknowledge register. That register returns the winning index already scaled to a 4-byte table offset, so the handler address is the table base plus the returned value. In hardware vector mode, the block drives a ready-made handler address, formed from a programmable aligned table base ORed with the index times four. The processor then signals that it took the vector with a single pulse.

Software accesses the block over a simple word-addressed register bus. Reads are combinational and writes take effect at the clock edge. A nesting stack keeps the thresholds that were interrupted, and an end-of-interrupt write returns to the previous threshold.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `cpu_irq` and `hw_vec_valid` are 0. The CTRL (word 0x00), CURPRI (0x01) and VTBASE (0x04) registers and every priority register (0x20+i for source i) read 0.
- R2: Request lines pass through a two-flop synchronizer. A line raised before a clock edge can first assert `cpu_irq` after the second rising edge, never after the first.
- R3: A source whose priority is 0 is masked. It never asserts `cpu_irq` and never wins arbitration.
- R4: Among the eligible sources, the one with the highest priority wins. On a tie, the lowest index wins.
- R5: A read of ACK (0x02) returns the winning index in bits [6:2], with all other bits 0. When no source is eligible, the read returns 0x8000_0000 and changes no state.
- R6: An acknowledge sets CURPRI to the winner's priority. A source is eligible, and can assert `cpu_irq`, only while its priority is strictly greater than CURPRI.
- R7: A write to EOI (0x03) restores the CURPRI value that was in force before the most recent unreturned acknowledge, in last-in first-out order. An EOI with no acknowledge outstanding leaves CURPRI at 0.
- R8: CTRL bit 0 selects the mode: 0 is software vector mode, 1 is hardware vector mode. `hw_vec_valid` equals `cpu_irq` in mode 1 and is 0 in mode 0. `hw_vec_addr` is VTBASE ORed with the winning index times 4.
- R9: A pulse on `vec_taken` acts as an acknowledge in hardware vector mode and is ignored in software vector mode.
- R10: VTBASE stores bits [31:11] of the written value. Its bits [10:0] always read 0.
- R11: The index of a request line is fixed. A priority written at 0x20+i applies only to source i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC (32) | Level-sensitive request lines; bit i is source i |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| vec_taken | input | 1 | Hardware-mode acknowledge pulse |
| cpu_irq | output | 1 | Merged interrupt request to the processor |
| hw_vec_valid | output | 1 | Handler address valid (hardware mode) |
| hw_vec_addr | output | 32 | Handler address |

## Verification
The bench targets ties on priority between a high and a low index. A design that scans from the wrong end would report index 30 instead of 2. It checks that an equal-priority source stays blocked after an acknowledge, which catches a threshold compare of "greater or equal". It unwinds nested acknowledges with EOI writes, and it issues an EOI on an empty stack: a design that pops in the wrong order or underflows would leave a wrong CURPRI. It also checks the synchronizer latency one edge at a time. It confirms that `vec_taken` and `hw_vec_valid` are dead in software mode, and that the base register drops its low bits. A mismatch in either mode would show up as a wrong handler address.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC  = 32,
  parameter int PW    = 4,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            reg_en,
  input  logic            reg_wr,
  input  logic [5:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            vec_taken,
  output logic            cpu_irq,
  output logic            hw_vec_valid,
  output logic [31:0]     hw_vec_addr
);
  localparam int IW   = $clog2(NSRC);
  localparam int SPW  = $clog2(DEPTH + 1);
  localparam int STW  = $clog2(DEPTH);
  localparam logic [5:0] A_CTRL = 6'h00, A_CUR = 6'h01, A_ACK = 6'h02,
                         A_EOI = 6'h03, A_BASE = 6'h04;
  localparam logic [31:0] SPURIOUS = 32'h8000_0000;

  logic [NSRC-1:0] sync1, sync2;
  logic [PW-1:0]   prio [NSRC];
  logic            mode;
  logic [20:0]     vtbase;
  logic [PW-1:0]   curpri;
  logic [PW-1:0]   stk [DEPTH];
  logic [SPW-1:0]  sp;
  logic [SPW-1:0]  sp_dec;
  logic [PW-1:0]   win_p;
  logic [IW-1:0]   win_i;
  logic            found;
  logic            rd_ack, wr_eoi, ack_fire;
  logic            unused_wbits;

  assign unused_wbits = ^reg_wdata[10:PW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= src_req;
      sync2 <= sync1;
    end

  always_comb begin
    win_p = '0;
    win_i = '0;
    for (int i = 0; i < NSRC; i++)
      if (sync2[i] && prio[i] > curpri && prio[i] > win_p) begin
        win_p = prio[i];
        win_i = IW'(i);
      end
  end

  assign found        = win_p != '0;
  assign cpu_irq      = found;
  assign hw_vec_valid = mode & found;
  assign hw_vec_addr  = {vtbase, 11'b0} | {{(30-IW){1'b0}}, win_i, 2'b00};

  assign rd_ack   = reg_en & ~reg_wr & (reg_addr == A_ACK);
  assign wr_eoi   = reg_en & reg_wr & (reg_addr == A_EOI);
  assign ack_fire = (rd_ack | (mode & vec_taken)) & found;
  assign sp_dec   = sp - 1'b1;

  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_wr) begin
      if (reg_addr[5])
        reg_rdata = {{(32-PW){1'b0}}, prio[reg_addr[IW-1:0]]};
      else
        case (reg_addr)
          A_CTRL: reg_rdata = {31'b0, mode};
          A_CUR:  reg_rdata = {{(32-PW){1'b0}}, curpri};
          A_ACK:  reg_rdata = found ? {{(30-IW){1'b0}}, win_i, 2'b00} : SPURIOUS;
          A_BASE: reg_rdata = {vtbase, 11'b0};
          default: reg_rdata = '0;
        endcase
    end
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) prio[g] <= '0;
        else if (reg_en && reg_wr && reg_addr[5] && reg_addr[IW-1:0] == IW'(g))
          prio[g] <= reg_wdata[PW-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode   <= 1'b0;
      vtbase <= '0;
    end else if (reg_en && reg_wr) begin
      if (reg_addr == A_CTRL) mode <= reg_wdata[0];
      if (reg_addr == A_BASE) vtbase <= reg_wdata[31:11];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      curpri <= '0;
      sp     <= '0;
      for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
    end else if (ack_fire) begin
      stk[sp[STW-1:0]] <= curpri;
      sp               <= sp + 1'b1;
      curpri           <= win_p;
    end else if (wr_eoi && sp != '0) begin
      curpri <= stk[sp_dec[STW-1:0]];
      sp     <= sp_dec;
    end

  AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> curpri > $past(curpri)); // R6
  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> stk[sp_dec[STW-1:0]] == $past(curpri)); // R7
  AST_EOI_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eoi && !ack_fire && sp != '0) |=> curpri < $past(curpri)); // R7
  AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !found) |=> ($stable(curpri) && $stable(sp))); // R5
  AST_STACK_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |-> sp < SPW'(DEPTH)); // R7
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [31:0] src_req = '0;
  logic        reg_en = 0, reg_wr = 0, vec_taken = 0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cpu_irq, hw_vec_valid;
  logic [31:0] hw_vec_addr;
  int          n_chk = 0, n_bad = 0;
  logic        finished = 0;

  irq_vector_ctrl u0 (.clk, .rst_n, .src_req, .reg_en, .reg_wr, .reg_addr,
    .reg_wdata, .reg_rdata, .vec_taken, .cpu_irq, .hw_vec_valid, .hw_vec_addr);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_en = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_wr = 0; reg_addr = a;
    #2 d = reg_rdata;
    @(posedge clk); #1 reg_en = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, cpu_irq}, 0);
    chk("R1 hw_valid", {31'b0, hw_vec_valid}, 0);
    rd(6'h00, d); chk("R1 ctrl", d, 0);
    rd(6'h01, d); chk("R1 curpri", d, 0);
    rd(6'h04, d); chk("R1 vtbase", d, 0);
    rd(6'h25, d); chk("R1 prio5", d, 0);
  endtask

  task automatic t_mask_latency();
    logic [31:0] d;
    @(negedge clk); src_req[3] = 1;
    settle();
    chk("R3 masked irq", {31'b0, cpu_irq}, 0);
    rd(6'h02, d); chk("R5 spurious", d, 32'h8000_0000);
    rd(6'h01, d); chk("R5 spurious curpri", d, 0);
    wr(6'h23, 2);
    rd(6'h24, d); chk("R11 prio4 untouched", d, 0);
    rd(6'h23, d); chk("R11 prio3", d, 2);
    @(negedge clk); src_req[3] = 0;
    settle();
    chk("R2 irq drops", {31'b0, cpu_irq}, 0);
    @(negedge clk); src_req[3] = 1;
    @(posedge clk); #1 chk("R2 first edge", {31'b0, cpu_irq}, 0);
    @(posedge clk); #1 chk("R2 second edge", {31'b0, cpu_irq}, 1);
    @(negedge clk); src_req[3] = 0;
    settle();
  endtask

  task automatic t_arb_nest();
    logic [31:0] d;
    wr(6'h27, 5); wr(6'h29, 9); wr(6'h2C, 9); wr(6'h34, 12);
    @(negedge clk); src_req[7] = 1; src_req[9] = 1; src_req[12] = 1;
    settle();
    chk("R2 irq on", {31'b0, cpu_irq}, 1);
    rd(6'h02, d); chk("R4 tie lowest idx", d, 9 << 2);
    rd(6'h01, d); chk("R6 curpri", d, 9);
    chk("R6 equal blocked", {31'b0, cpu_irq}, 0);
    @(negedge clk); src_req[20] = 1;
    settle();
    chk("R6 higher passes", {31'b0, cpu_irq}, 1);
    rd(6'h02, d); chk("R4 highest wins", d, 20 << 2);
    rd(6'h01, d); chk("R6 curpri nested", d, 12);
    wr(6'h03, 0);
    rd(6'h01, d); chk("R7 first eoi", d, 9);
    wr(6'h03, 0);
    rd(6'h01, d); chk("R7 second eoi", d, 0);
    chk("R7 irq again", {31'b0, cpu_irq}, 1);
    wr(6'h03, 0);
    rd(6'h01, d); chk("R7 empty eoi", d, 0);
    @(negedge clk); src_req = '0;
    wr(6'h22, 6); wr(6'h3E, 6);
    @(negedge clk); src_req[30] = 1; src_req[2] = 1;
    settle();
    rd(6'h02, d); chk("R4 tie 2 vs 30", d, 2 << 2);
    wr(6'h03, 0);
    @(negedge clk); src_req = '0;
    settle();
  endtask

  task automatic t_hw_mode();
    logic [31:0] d;
    wr(6'h04, 32'h1234_5FFF);
    rd(6'h04, d); chk("R10 base align", d, 32'h1234_5800);
    wr(6'h00, 1);
    rd(6'h00, d); chk("R8 mode read", d, 1);
    wr(6'h31, 3);
    @(negedge clk); src_req[17] = 1;
    settle();
    chk("R8 hw valid", {31'b0, hw_vec_valid}, 1);
    chk("R8 hw addr", hw_vec_addr, 32'h1234_5844);
    @(negedge clk); vec_taken = 1;
    @(posedge clk); #1 vec_taken = 0;
    rd(6'h01, d); chk("R9 taken acks", d, 3);
    chk("R9 valid cleared", {31'b0, hw_vec_valid}, 0);
    wr(6'h03, 0);
    wr(6'h00, 0);
    #1 chk("R8 sw irq", {31'b0, cpu_irq}, 1);
    chk("R8 sw no valid", {31'b0, hw_vec_valid}, 0);
    @(negedge clk); vec_taken = 1;
    @(posedge clk); #1 vec_taken = 0;
    rd(6'h01, d); chk("R9 ignored in sw", d, 0);
    chk("R9 irq still on", {31'b0, cpu_irq}, 1);
    @(negedge clk); src_req = '0;
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_mask_latency();
    t_arb_nest();
    t_hw_mode();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule